// File: doc/BRIEF.md
# Two-Bank Synchronous DRAM Read and Precharge Model

This block is a cycle-accurate, synthesizable stand-in for the device side of a two-bank synchronous DRAM. It is meant for controller verification and emulation. It decodes row-open, column-read, close (precharge) and no-op commands from the usual active-low strobe pins and the address bus. It keeps a small state machine per bank and returns four-beat read bursts on a 16-bit data bus after a selectable CAS latency of 2 or 3 clocks. The read data comes from a deterministic pattern built from the bank, the open row and the burst column, so a controller bench can tell every beat apart.

Two timing minimums are counted in clocks and enforced per bank. The first is the shortest time a row must stay open before it may be closed. The second is the recovery time after a close before the bank may be opened again. A close command can address one bank or both banks. A close to the bank whose burst is still running cuts that burst short: the data bus goes quiet exactly one CAS latency after the close. Any command that breaks the bank rules is dropped, and it raises a sticky error output that only reset clears.

Top module: `sdr2b_core`

## Requirements
- R1: With `cs_n` low, the strobes {`ras_n`,`cas_n`,`we_n`} decode as 011 open-row, 101 read, 010 close and 111 no-op. Every other code, and any cycle with `cs_n` high, is a no-op. After reset both banks are idle, `dq_valid`, `dq_oe` and `err` are low, and `dq` is zero.
- R2: An open-row command to an idle bank `addr[11]` stores row bits `addr[6:0]`. A read of an open bank with column `addr[7:0]` gives four beats on consecutive cycles. Beat k (0..3) is `{bank, row[6:0], col[7:2], (col[1:0]+k) mod 4}`.
- R3: With `cas_lat`=0 the first beat appears 2 cycles after the read cycle, and with `cas_lat`=1 it appears 3 cycles after. `cas_lat` is only changed while no read data is pending.
- R4: `dq_valid` and `dq_oe` are high exactly in the cycles that carry read beats. In all other cycles `dq` is zero.
- R5: A close with `addr[10]` low closes only the bank selected by `addr[11]`. The other bank stays open and readable.
- R6: A close with `addr[10]` high closes both banks, whatever the value of `addr[11]`.
- R7: A close reaching an open bank fewer than T_RAS (default 5) cycles after that bank's open command is an error and is ignored: the bank stays open. At exactly T_RAS cycles the close is accepted.
- R8: An open-row command fewer than T_RP (default 3) cycles after the bank's close is an error and is ignored. At exactly T_RP cycles it is accepted.
- R9: An open-row command to an open bank is an error and leaves the stored row unchanged. A read of a bank that is not open is an error and produces no data.
- R10: An accepted close at cycle p that targets the bank of the running burst suppresses every beat due at cycle p+CL or later. Beats due earlier are still delivered.
- R11: A close that targets only the other bank does not shorten the running burst.
- R12: A read issued while a burst runs ends the old burst's beats that are due at the new read's first-beat cycle or later. The new burst starts CL cycles after the new read.
- R13: `err` stays high from the cycle after the first illegal command until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Row/column address; bit 11 selects the bank, bit 10 selects the all-bank close |
| cas_lat | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| dq | output | 16 | Read data, zero when idle |
| dq_oe | output | 1 | Data bus output enable |
| dq_valid | output | 1 | Read beat present |
| err | output | 1 | Sticky protocol violation flag |

## Verification
Directed sequences set each close command one cycle before, at, and after its row-open and recovery limits. This separates an off-by-one in either counter from a correct one. Truncation is driven with single-bank and all-bank closes at both latencies, and with a close aimed at the idle bank, so that a cut placed in the wrong cycle or on the wrong bank shows up as a missing or extra beat. Back-to-back reads on different banks, with starting columns that wrap inside the burst, check the burst order and the read-replaces-read rule. Seeded random command streams that include undecoded codes and deselected cycles then run against a cycle-by-cycle reference model.

// File: rtl/sdr2b_pkg.sv
package sdr2b_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_OPEN  = 2'd1,
    BK_PRECH = 2'd2
  } bank_st_e;

  typedef struct packed {
    cmd_e cmd;
    logic bank;
    logic all_bk;
  } dec_t;

endpackage

// File: rtl/sdr2b_cmd_dec.sv
module sdr2b_cmd_dec
  import sdr2b_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_BIT = 11,
  parameter int AP_BIT   = 10
) (
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  always_comb begin
    dec.bank   = addr[BANK_BIT];
    dec.all_bk = addr[AP_BIT];
    dec.cmd    = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  dec.cmd = CMD_ACT;
        3'b101:  dec.cmd = CMD_RD;
        3'b010:  dec.cmd = CMD_PRE;
        default: dec.cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdr2b_bank.sv
module sdr2b_bank
  import sdr2b_pkg::*;
#(
  parameter int T_RAS = 5,
  parameter int T_RP  = 3,
  parameter int ROW_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             act_ok,
  output logic             pre_ok,
  output logic             rd_ok,
  output logic [ROW_W-1:0] row
);

  localparam int CNT_MAX = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RAS_LOAD = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic             row_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    row_en = 1'b0;
    unique case (st_q)
      BK_IDLE: begin
        if (act_go) begin
          st_d   = BK_OPEN;
          cnt_d  = RAS_LOAD;
          row_en = 1'b1;
        end
      end
      BK_OPEN: begin
        if (pre_go) begin
          st_d  = BK_PRECH;
          cnt_d = RP_LOAD;
        end
      end
      BK_PRECH: begin
        if (act_go) begin
          st_d   = BK_OPEN;
          cnt_d  = RAS_LOAD;
          row_en = 1'b1;
        end else if (cnt_q == '0) begin
          st_d = BK_IDLE;
        end
      end
      default: st_d = BK_IDLE;
    endcase
  end

  assign act_ok = (st_q == BK_IDLE) || ((st_q == BK_PRECH) && (cnt_q == '0));
  assign pre_ok = (st_q != BK_OPEN) || (cnt_q == '0);
  assign rd_ok  = (st_q == BK_OPEN);
  assign row    = row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (row_en) begin
      row_q <= row_in;
    end
  end

  // R5
  close_open_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_OPEN && pre_go) |=> (st_q == BK_PRECH));

  // R8
  no_early_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_PRECH && cnt_q != '0) |=> (st_q != BK_OPEN));

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_IDLE && !act_go) |=> (st_q == BK_IDLE));

endmodule

// File: rtl/sdr2b_rd_pipe.sv
module sdr2b_rd_pipe #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 7,
  parameter int MIN_CL = 2,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cas_lat,
  input  logic              rd_go,
  input  logic              rd_bank,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              pre_go,
  input  logic              pre_all,
  input  logic              pre_bank,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe,
  output logic              dq_valid
);

  localparam int MAX_CL = MIN_CL + 1;
  localparam int BEAT_W = $clog2(BURST);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST - 1);

  function automatic logic [DATA_W-1:0] beat_word(
    input logic             b,
    input logic [ROW_W-1:0] r,
    input logic [COL_W-1:0] c,
    input logic [BEAT_W-1:0] k
  );
    logic [BEAT_W-1:0] low;
    low = c[BEAT_W-1:0] + k;
    return {b, r, c[COL_W-1:BEAT_W], low};
  endfunction

  logic              gen_act_q, gen_act_d;
  logic              gen_bank_q, gen_bank_d;
  logic [ROW_W-1:0]  gen_row_q, gen_row_d;
  logic [COL_W-1:0]  gen_col_q, gen_col_d;
  logic [BEAT_W-1:0] gen_beat_q, gen_beat_d;
  logic              kill;
  logic              g_vld;
  logic [DATA_W-1:0] g_data;

  logic [MAX_CL-1:0] vld_q;
  logic [DATA_W-1:0] dat_q [MAX_CL];

  assign kill = pre_go && (pre_all || (pre_bank == gen_bank_q));

  always_comb begin
    gen_act_d  = 1'b0;
    gen_bank_d = gen_bank_q;
    gen_row_d  = gen_row_q;
    gen_col_d  = gen_col_q;
    gen_beat_d = gen_beat_q;
    g_vld      = 1'b0;
    g_data     = '0;
    if (rd_go) begin
      g_vld      = 1'b1;
      g_data     = beat_word(rd_bank, rd_row, rd_col, '0);
      gen_act_d  = 1'b1;
      gen_bank_d = rd_bank;
      gen_row_d  = rd_row;
      gen_col_d  = rd_col;
      gen_beat_d = BEAT_W'(1);
    end else if (gen_act_q && !kill) begin
      g_vld      = 1'b1;
      g_data     = beat_word(gen_bank_q, gen_row_q, gen_col_q, gen_beat_q);
      gen_act_d  = (gen_beat_q != LAST_BEAT);
      gen_beat_d = gen_beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_act_q  <= 1'b0;
      gen_bank_q <= 1'b0;
      gen_row_q  <= '0;
      gen_col_q  <= '0;
      gen_beat_q <= '0;
    end else begin
      gen_act_q  <= gen_act_d;
      gen_bank_q <= gen_bank_d;
      gen_row_q  <= gen_row_d;
      gen_col_q  <= gen_col_d;
      gen_beat_q <= gen_beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int s = 0; s < MAX_CL; s++) dat_q[s] <= '0;
    end else begin
      vld_q <= {vld_q[MAX_CL-2:0], g_vld};
      if (g_vld) dat_q[0] <= g_data;
      for (int s = 1; s < MAX_CL; s++) begin
        if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
      end
    end
  end

  always_comb begin
    if (cas_lat) begin
      dq_valid = vld_q[MAX_CL-1];
      dq       = vld_q[MAX_CL-1] ? dat_q[MAX_CL-1] : '0;
    end else begin
      dq_valid = vld_q[MIN_CL-1];
      dq       = vld_q[MIN_CL-1] ? dat_q[MIN_CL-1] : '0;
    end
  end
  assign dq_oe = dq_valid;

  // R2
  first_beat_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> vld_q[0]);

  // R2
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_act_q && !kill && !rd_go && gen_beat_q == LAST_BEAT) |=> !gen_act_q);

  // R10
  trunc_stops_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !rd_go) |=> !gen_act_q);

endmodule

// File: rtl/sdr2b_core.sv
module sdr2b_core
  import sdr2b_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int COL_W    = 8,
  parameter int BANK_BIT = 11,
  parameter int AP_BIT   = 10,
  parameter int T_RAS    = 5,
  parameter int T_RP     = 3,
  parameter int MIN_CL   = 2,
  parameter int BURST    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cas_lat,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe,
  output logic              dq_valid,
  output logic              err
);

  localparam int ROW_W  = DATA_W - COL_W - 1;
  localparam int NBANKS = 2;

  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  dec_t dec;
  logic unused_addr;
  assign unused_addr = ^addr;

  sdr2b_cmd_dec #(
    .ADDR_W  (ADDR_W),
    .BANK_BIT(BANK_BIT),
    .AP_BIT  (AP_BIT)
  ) u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .addr (addr),
    .dec  (dec)
  );

  logic [NBANKS-1:0] act_ok, pre_ok, rd_ok;
  logic [ROW_W-1:0]  row_q [NBANKS];
  logic              act_go, pre_go, rd_go, pre_legal, bad;
  logic              err_q;

  always_comb begin
    pre_legal = dec.all_bk ? (&pre_ok) : pre_ok[dec.bank];
    act_go    = (dec.cmd == CMD_ACT) && act_ok[dec.bank];
    pre_go    = (dec.cmd == CMD_PRE) && pre_legal;
    rd_go     = (dec.cmd == CMD_RD)  && rd_ok[dec.bank];
    bad       = ((dec.cmd == CMD_ACT) && !act_ok[dec.bank]) ||
                ((dec.cmd == CMD_PRE) && !pre_legal) ||
                ((dec.cmd == CMD_RD)  && !rd_ok[dec.bank]);
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    sdr2b_bank #(
      .T_RAS(T_RAS),
      .T_RP (T_RP),
      .ROW_W(ROW_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n_s),
      .act_go(act_go && (dec.bank == 1'(b))),
      .pre_go(pre_go && (dec.all_bk || (dec.bank == 1'(b)))),
      .row_in(addr[ROW_W-1:0]),
      .act_ok(act_ok[b]),
      .pre_ok(pre_ok[b]),
      .rd_ok (rd_ok[b]),
      .row   (row_q[b])
    );
  end

  sdr2b_rd_pipe #(
    .DATA_W(DATA_W),
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .MIN_CL(MIN_CL),
    .BURST (BURST)
  ) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cas_lat (cas_lat),
    .rd_go   (rd_go),
    .rd_bank (dec.bank),
    .rd_row  (row_q[dec.bank]),
    .rd_col  (addr[COL_W-1:0]),
    .pre_go  (pre_go),
    .pre_all (dec.all_bk),
    .pre_bank(dec.bank),
    .dq      (dq),
    .dq_oe   (dq_oe),
    .dq_valid(dq_valid)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      err_q <= 1'b0;
    end else if (bad) begin
      err_q <= 1'b1;
    end
  end
  assign err = err_q;

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    err |=> err);

  // R9
  bad_read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((dec.cmd == CMD_RD) && !rd_ok[dec.bank]) |=> err);

  // R7
  early_close_flags_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((dec.cmd == CMD_PRE) && !pre_legal) |=> err);

endmodule

// File: tb/tb_sdr2b_core.sv
module tb_sdr2b_core;

  localparam int T_RAS  = 5;
  localparam int T_RP   = 3;
  localparam int MIN_CL = 2;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_PRE = 3, C_OTH = 4, C_DES = 5;

  logic        clk;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [11:0] addr;
  logic        cas_lat;
  logic [15:0] dq;
  logic        dq_oe, dq_valid, err;

  sdr2b_core dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cas_lat(cas_lat), .dq(dq), .dq_oe(dq_oe),
    .dq_valid(dq_valid), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  int          bst [2];
  int          tact [2];
  int          tpre [2];
  logic [6:0]  brow [2];
  logic        exp_err;
  logic        ev [16];
  logic [15:0] ed [16];
  logic        eb [16];

  function automatic logic [15:0] pat(logic b, logic [6:0] r, logic [7:0] c, int k);
    logic [1:0] low;
    low = 2'(int'(c[1:0]) + k);
    return {b, r, c[7:2], low};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin ev[i] = 1'b0; ed[i] = '0; eb[i] = 1'b0; end
    for (int b = 0; b < 2; b++) begin bst[b] = 0; tact[b] = 0; tpre[b] = 0; brow[b] = '0; end
    exp_err = 1'b0;
  endtask

  task automatic compare_now();
    int s;
    s = cyc % 16;
    chk(cur_req, "dq_valid", 32'(dq_valid), 32'(ev[s]));
    chk(cur_req, "dq_oe", 32'(dq_oe), 32'(ev[s]));
    chk(cur_req, "dq", 32'(dq), ev[s] ? 32'(ed[s]) : 32'd0);
    chk(cur_req, "err", 32'(err), 32'(exp_err));
    ev[s] = 1'b0;
  endtask

  task automatic model_cmd(int c, logic b, logic ap, logic [10:0] a);
    int cl;
    bit ok;
    cl = MIN_CL + int'(cas_lat);
    case (c)
      C_ACT: begin
        ok = (bst[b] == 0) || (bst[b] == 2 && (cyc - tpre[b]) >= T_RP);
        if (ok) begin bst[b] = 1; tact[b] = cyc; brow[b] = a[6:0]; end
        else exp_err = 1'b1;
      end
      C_RD: begin
        if (bst[b] == 1) begin
          for (int o = 0; o < 8; o++) ev[(cyc + cl + o) % 16] = 1'b0;
          for (int k = 0; k < 4; k++) begin
            ev[(cyc + cl + k) % 16] = 1'b1;
            ed[(cyc + cl + k) % 16] = pat(b, brow[b], a[7:0], k);
            eb[(cyc + cl + k) % 16] = b;
          end
        end else exp_err = 1'b1;
      end
      C_PRE: begin
        ok = 1;
        for (int bb = 0; bb < 2; bb++)
          if ((ap || bb == int'(b)) && bst[bb] == 1 && (cyc - tact[bb]) < T_RAS) ok = 0;
        if (ok) begin
          for (int bb = 0; bb < 2; bb++)
            if ((ap || bb == int'(b)) && bst[bb] == 1) begin bst[bb] = 2; tpre[bb] = cyc; end
          for (int o = 0; o < 8; o++) begin
            int s;
            s = (cyc + cl + o) % 16;
            if (ev[s] && (ap || eb[s] == b)) ev[s] = 1'b0;
          end
        end else exp_err = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic step(int c, logic b, logic ap, logic [10:0] a);
    logic [3:0] pins;
    @(negedge clk);
    if (done) return;
    compare_now();
    model_cmd(c, b, ap, a);
    case (c)
      C_ACT:   pins = 4'b0011;
      C_RD:    pins = 4'b0101;
      C_PRE:   pins = 4'b0010;
      C_OTH: begin
        case ($urandom % 4)
          0: pins = 4'b0100;
          1: pins = 4'b0001;
          2: pins = 4'b0000;
          default: pins = 4'b0110;
        endcase
      end
      C_DES:   pins = {1'b1, 3'($urandom)};
      default: pins = 4'b0111;
    endcase
    {cs_n, ras_n, cas_n, we_n} = pins;
    addr = {b, (c == C_PRE) ? ap : a[10], a[9:0]};
    cyc++;
  endtask

  task automatic nops(int k);
    for (int i = 0; i < k; i++) step(C_NOP, 1'b0, 1'b0, 11'h0);
  endtask

  task automatic reset_dut(logic cl);
    @(negedge clk);
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    addr = '0;
    cas_lat = cl;
    repeat (3) @(negedge clk);
    chk("R1", "reset dq_valid", 32'(dq_valid), 32'd0);
    chk("R1", "reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R1", "reset dq", 32'(dq), 32'd0);
    chk("R1", "reset err", 32'(err), 32'd0);
    rst_n = 1'b1;
    model_clear();
    nops(4);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    addr = '0;
    cas_lat = 1'b0;
    model_clear();

    cur_req = "R1";
    reset_dut(1'b0);
    step(C_OTH, 1'b0, 1'b0, 11'h0);
    step(C_DES, 1'b1, 1'b0, 11'h0);
    nops(2);

    cur_req = "R2";
    step(C_ACT, 1'b0, 1'b0, 11'h015);
    step(C_RD, 1'b0, 1'b0, 11'h006);
    cur_req = "R4";
    nops(8);

    cur_req = "R3";
    reset_dut(1'b1);
    step(C_ACT, 1'b1, 1'b0, 11'h07f);
    step(C_RD, 1'b1, 1'b0, 11'h0f1);
    nops(8);

    cur_req = "R7";
    reset_dut(1'b0);
    step(C_ACT, 1'b1, 1'b0, 11'h033);
    nops(3);
    step(C_PRE, 1'b1, 1'b0, 11'h0);
    step(C_RD, 1'b1, 1'b0, 11'h010);
    nops(6);
    step(C_PRE, 1'b1, 1'b0, 11'h0);
    nops(4);

    reset_dut(1'b0);
    step(C_ACT, 1'b0, 1'b0, 11'h011);
    nops(4);
    step(C_PRE, 1'b0, 1'b0, 11'h0);
    cur_req = "R8";
    nops(2);
    step(C_ACT, 1'b0, 1'b0, 11'h022);
    step(C_RD, 1'b0, 1'b0, 11'h000);
    nops(6);
    step(C_PRE, 1'b0, 1'b0, 11'h0);
    nops(1);
    step(C_ACT, 1'b0, 1'b0, 11'h044);
    step(C_RD, 1'b0, 1'b0, 11'h001);
    cur_req = "R13";
    nops(10);

    cur_req = "R9";
    reset_dut(1'b0);
    step(C_ACT, 1'b0, 1'b0, 11'h005);
    step(C_ACT, 1'b0, 1'b0, 11'h009);
    step(C_RD, 1'b0, 1'b0, 11'h030);
    nops(6);
    step(C_RD, 1'b1, 1'b0, 11'h031);
    nops(6);

    cur_req = "R5";
    reset_dut(1'b0);
    step(C_ACT, 1'b0, 1'b0, 11'h001);
    step(C_ACT, 1'b1, 1'b0, 11'h002);
    nops(5);
    step(C_PRE, 1'b0, 1'b0, 11'h0);
    step(C_RD, 1'b1, 1'b0, 11'h044);
    nops(5);
    step(C_RD, 1'b0, 1'b0, 11'h045);
    nops(6);

    cur_req = "R6";
    reset_dut(1'b0);
    step(C_ACT, 1'b0, 1'b0, 11'h003);
    step(C_ACT, 1'b1, 1'b0, 11'h004);
    nops(5);
    step(C_PRE, 1'b0, 1'b1, 11'h0);
    nops(1);
    step(C_RD, 1'b1, 1'b0, 11'h020);
    nops(5);

    cur_req = "R10";
    for (int l = 0; l < 2; l++) begin
      reset_dut(l[0]);
      step(C_ACT, 1'b0, 1'b0, 11'h00a);
      nops(5);
      step(C_RD, 1'b0, 1'b0, 11'h008);
      nops(1);
      step(C_PRE, 1'b0, 1'b0, 11'h0);
      nops(8);
      step(C_ACT, 1'b1, 1'b0, 11'h00b);
      nops(5);
      step(C_RD, 1'b1, 1'b0, 11'h00d);
      step(C_PRE, 1'b0, 1'b1, 11'h0);
      nops(8);
    end

    cur_req = "R11";
    reset_dut(1'b0);
    step(C_ACT, 1'b0, 1'b0, 11'h021);
    step(C_ACT, 1'b1, 1'b0, 11'h022);
    nops(5);
    step(C_RD, 1'b0, 1'b0, 11'h00c);
    step(C_PRE, 1'b1, 1'b0, 11'h0);
    nops(8);

    cur_req = "R12";
    for (int l = 0; l < 2; l++) begin
      reset_dut(l[0]);
      step(C_ACT, 1'b0, 1'b0, 11'h001);
      step(C_ACT, 1'b1, 1'b0, 11'h002);
      nops(4);
      step(C_RD, 1'b0, 1'b0, 11'h000);
      nops(1);
      step(C_RD, 1'b1, 1'b0, 11'h00b);
      nops(8);
    end

    for (int seg = 0; seg < 6; seg++) begin
      cur_req = "R2";
      reset_dut(seg[0]);
      for (int i = 0; i < 600; i++) begin
        int r, c;
        r = int'($urandom % 16);
        if (r <= 4 || r == 15) c = C_NOP;
        else if (r <= 7) c = C_ACT;
        else if (r <= 10) c = C_RD;
        else if (r <= 12) c = C_PRE;
        else if (r == 13) c = C_OTH;
        else c = C_DES;
        step(c, 1'($urandom), ($urandom % 4) == 0, 11'($urandom));
      end
      nops(8);
    end

    report();
  end

endmodule